// File: doc/BRIEF.md
# Glitch-free power-of-two clock divider

This block takes a fast source clock and produces an output clock at the source rate divided by 1, 2, 4 or 8. The output has a 50% duty cycle for every ratio. A 2-bit ratio code picks the divisor. The code is not a plain exponent: the all-ones code selects pass-through of the source clock, and the other codes select 2, 4 and 8 in ascending order.

An active-high enable turns the output on and off. Both the enable and the ratio code are taken up only at a point where the output is low and a new period is about to begin. As a result, switching never cuts a high pulse short and never produces a low gap shorter than the high pulse before it.

A second output carries the divided clock divided again by 4, for observation. An asynchronous reset clears the internal counters and forces both outputs low.

Top module: `pow2_clkdiv`

## Requirements
- R1: Ratio code mapping: 2'b00 divides by 2, 2'b01 by 4, 2'b10 by 8, and 2'b11 passes the source clock through (divide by 1).
- R2: With a steady code and the enable held high, each high phase and each low phase of `clk_o` lasts exactly half of the selected period. For ratio P that is P/2 source cycles. For divide-by-1 it is half a source cycle, matching the source clock.
- R3: The enable is active high. Once a low enable has been taken up, `clk_o` stays low and `tap_o` does not change.
- R4: A change of enable or ratio takes effect only at a period boundary, where the output is low. Every high pulse of `clk_o` is exactly the full half-period of one of the four ratios. Every low phase lasts at least as long as the high pulse before it.
- R5: The ratio code is sampled only at the period boundary. A code change during a high or low phase does not alter that period.
- R6: While reset is asserted, `clk_o` and `tap_o` are low. After release with the enable low, both stay low.
- R7: `tap_o` toggles on every second rising edge of `clk_o`. Its high and low phases therefore each last two output periods (4P half source cycles).
- R8: In divide-by-1 mode, `clk_o` follows the source clock and `tap_o` has a period of four source cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock |
| arst_i | input | 1 | Asynchronous reset, active high |
| ratio_code_i | input | CODE_W (2) | Ratio code: 00=/2, 01=/4, 10=/8, 11=/1 |
| out_en_i | input | 1 | Output enable, active high |
| clk_o | output | 1 | Divided output clock |
| tap_o | output | 1 | Output clock divided by 2**TAP_LOG (4) for observation |

## Verification
The bench measures every high and low run of both outputs in half source cycles. It sweeps all sixteen ordered pairs of ratio codes, and it toggles the enable at every phase offset within the longest period.

A design that took up a new code or enable mid-period would show a high pulse of a width that belongs to no ratio, or a low gap shorter than the preceding pulse. Both are flagged as runts.

Three further cases get their own checks:
- A code change inside a divide-by-8 pulse, which a wrong design would truncate.
- Leaving divide-by-1 mode, where a badly timed gate would cut the pass-through pulse in half.
- The tap, where counting the wrong edges would double or halve its period.

// File: rtl/pow2div_pkg.sv
`timescale 1ns/1ps
package pow2div_pkg;
   // Code all-ones selects pass-through (log 0); otherwise log = code + 1.
   function automatic int unsigned ratio_log(input int unsigned code, input int unsigned cw);
      int unsigned all_ones;
      all_ones = (32'd1 << cw) - 32'd1;
      if (code == all_ones) return 0;
      return code + 1;
   endfunction
endpackage

// File: rtl/pow2div_sync.sv
`timescale 1ns/1ps
module pow2div_sync
   import pow2div_pkg::*;
#(
   parameter int CODE_W = 2,
   parameter int MAX_LOG = 3,
   parameter int LOG_W = 2,
   parameter int PH_W = 3
) (
   input  logic              clk_i,
   input  logic              arst_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              en_i,
   output logic              dq_o,
   output logic              byp_o,
   output logic              launch_o,
   output logic              bnd_o,
   output logic [LOG_W-1:0]  act_log_o,
   output logic              act_en_o
);
   logic [LOG_W-1:0] act_log_q, new_log;
   logic             act_en_q, byp_q, dq_q, run, bnd, launch, dq_nxt;
   logic [PH_W-1:0]  ph_q, ph_nxt, per_m1;

   always_comb begin
      new_log = LOG_W'(ratio_log(32'(code_i), CODE_W));
      per_m1  = PH_W'((32'd1 << act_log_q) - 32'd1);
      run     = act_en_q && (act_log_q != '0);
      bnd     = !run || (ph_q == per_m1);
      launch  = bnd && en_i && (new_log != '0);
      ph_nxt  = ph_q + 1'b1;
      dq_nxt  = (32'(ph_nxt) < (32'd1 << (act_log_q - 1'b1)));
   end

   always_ff @(posedge clk_i or posedge arst_i) begin
      if (arst_i) begin
         act_log_q <= '0;
         act_en_q  <= 1'b0;
         byp_q     <= 1'b0;
         dq_q      <= 1'b0;
         ph_q      <= '0;
      end else if (bnd) begin
         act_log_q <= new_log;
         act_en_q  <= en_i;
         byp_q     <= en_i && (new_log == '0);
         dq_q      <= launch;
         ph_q      <= '0;
      end else begin
         dq_q      <= dq_nxt;
         ph_q      <= ph_nxt;
      end
   end

   assign dq_o      = dq_q;
   assign byp_o     = byp_q;
   assign launch_o  = launch;
   assign bnd_o     = bnd;
   assign act_log_o = act_log_q;
   assign act_en_o  = act_en_q;
endmodule

// File: rtl/pow2div_out.sv
`timescale 1ns/1ps
module pow2div_out (
   input  logic clk_i,
   input  logic arst_i,
   input  logic byp_i,
   input  logic dq_i,
   output logic gate_o,
   output logic clk_o
);
   logic gate_q;

   // Gate changes only while the source clock is low.
   always_ff @(negedge clk_i or posedge arst_i) begin
      if (arst_i) gate_q <= 1'b0;
      else        gate_q <= byp_i;
   end

   assign gate_o = gate_q;
   assign clk_o  = (clk_i & gate_q) | dq_i;
endmodule

// File: rtl/pow2div_tap.sv
`timescale 1ns/1ps
module pow2div_tap #(
   parameter int TAP_LOG = 2
) (
   input  logic clk_i,
   input  logic arst_i,
   input  logic start_i,
   output logic tap_o
);
   generate
      if (TAP_LOG == 1) begin : g_toggle
         logic t_q;
         always_ff @(posedge clk_i or posedge arst_i) begin
            if (arst_i)       t_q <= 1'b0;
            else if (start_i) t_q <= !t_q;
         end
         assign tap_o = t_q;
      end else begin : g_count
         logic [TAP_LOG-1:0] cnt_q;
         always_ff @(posedge clk_i or posedge arst_i) begin
            if (arst_i)       cnt_q <= '0;
            else if (start_i) cnt_q <= cnt_q + 1'b1;
         end
         assign tap_o = cnt_q[TAP_LOG-1];
      end
   endgenerate
endmodule

// File: rtl/pow2_clkdiv.sv
`timescale 1ns/1ps
module pow2_clkdiv #(
   parameter int CODE_W = 2,
   parameter int TAP_LOG = 2
) (
   input  logic              clk_i,
   input  logic              arst_i,
   input  logic [CODE_W-1:0] ratio_code_i,
   input  logic              out_en_i,
   output logic              clk_o,
   output logic              tap_o
);
   localparam int MAX_LOG = (1 << CODE_W) - 1;
   localparam int LOG_W   = $clog2(MAX_LOG + 1);
   localparam int PH_W    = MAX_LOG;

   generate
      if (CODE_W < 1 || CODE_W > 3) begin : g_bad_code_w
         $error("pow2_clkdiv: CODE_W must be 1..3");
      end
      if (TAP_LOG < 1 || TAP_LOG > 8) begin : g_bad_tap
         $error("pow2_clkdiv: TAP_LOG must be 1..8");
      end
   endgenerate

   logic             dq_w, byp_w, launch_w, bnd_w, gate_w, act_en_w, start_w;
   logic [LOG_W-1:0] act_log_w;

   pow2div_sync #(
      .CODE_W(CODE_W), .MAX_LOG(MAX_LOG), .LOG_W(LOG_W), .PH_W(PH_W)
   ) u_sync (
      .clk_i(clk_i), .arst_i(arst_i), .code_i(ratio_code_i), .en_i(out_en_i),
      .dq_o(dq_w), .byp_o(byp_w), .launch_o(launch_w), .bnd_o(bnd_w),
      .act_log_o(act_log_w), .act_en_o(act_en_w)
   );

   pow2div_out u_out (
      .clk_i(clk_i), .arst_i(arst_i), .byp_i(byp_w), .dq_i(dq_w),
      .gate_o(gate_w), .clk_o(clk_o)
   );

   // A pulse begins at this edge if the bypass gate is open or a divided pulse launches.
   assign start_w = launch_w | gate_w;

   pow2div_tap #(.TAP_LOG(TAP_LOG)) u_tap (
      .clk_i(clk_i), .arst_i(arst_i), .start_i(start_w), .tap_o(tap_o)
   );
endmodule

// File: rtl/pow2_clkdiv_chk.sv
`timescale 1ns/1ps
module pow2_clkdiv_chk #(
   parameter int LOG_W = 2
) (
   input logic             clk_i,
   input logic             arst_i,
   input logic             tap_o,
   input logic             dq,
   input logic             gate,
   input logic             start,
   input logic             bnd,
   input logic [LOG_W-1:0] act_log,
   input logic             act_en
);
   logic        prev_dq;
   int unsigned hi_len, exp_half;

   always_ff @(posedge clk_i or posedge arst_i) begin
      if (arst_i) begin
         prev_dq  <= 1'b0;
         hi_len   <= 0;
         exp_half <= 0;
      end else begin
         prev_dq <= dq;
         if (dq && !prev_dq) begin
            hi_len   <= 1;
            exp_half <= 32'd1 << (act_log - 1'b1);
         end else if (dq) begin
            hi_len <= hi_len + 1;
         end
      end
   end

   assert_half_width_R2: assert property (@(posedge clk_i) disable iff (arst_i)
      (!dq && prev_dq) |-> (hi_len == exp_half));

   assert_code_hold_R5: assert property (@(posedge clk_i) disable iff (arst_i)
      !bnd |=> $stable(act_log));

   assert_off_low_R3: assert property (@(posedge clk_i) disable iff (arst_i)
      (!act_en && !$past(act_en)) |-> (!dq && !gate));

   assert_one_source_R4: assert property (@(posedge clk_i) disable iff (arst_i)
      !(dq && gate));

   assert_tap_step_R7: assert property (@(posedge clk_i) disable iff (arst_i)
      !start |=> $stable(tap_o));
endmodule

bind pow2_clkdiv pow2_clkdiv_chk #(.LOG_W(LOG_W)) u_chk (
   .clk_i(clk_i), .arst_i(arst_i), .tap_o(tap_o), .dq(dq_w), .gate(gate_w),
   .start(start_w), .bnd(bnd_w), .act_log(act_log_w), .act_en(act_en_w)
);

// File: tb/pow2_clkdiv_test.sv
`timescale 1ns/1ps
module pow2_clkdiv_test;
   logic       clk = 1'b0;
   logic       arst = 1'b1;
   logic [1:0] code = 2'b00;
   logic       en = 1'b0;
   logic       fout, tap;

   int vectors = 0, fails = 0, runts = 0;
   int run_f = 0, run_t = 0, seen_f = 0, seen_t = 0;
   int last_hi = 0, last_lo = 0, tap_hi = 0, tap_lo = 0;
   logic prev_f = 1'b0, prev_t = 1'b0;
   bit done = 0;

   pow2_clkdiv uut (
      .clk_i(clk), .arst_i(arst), .ratio_code_i(code), .out_en_i(en),
      .clk_o(fout), .tap_o(tap)
   );

   always #2 clk = !clk;

   // Run-length monitor, one sample per half source cycle.
   always @(clk) begin
      #1;
      if (arst) begin
         seen_f = 0; seen_t = 0; run_f = 0; run_t = 0;
         prev_f = fout; prev_t = tap;
      end else begin
         if (fout != prev_f) begin
            if (!fout) begin
               if (seen_f > 0 && !(run_f == 1 || run_f == 2 || run_f == 4 || run_f == 8)) runts++;
               last_hi = run_f;
            end else begin
               if (seen_f > 1 && run_f < last_hi) runts++;
               last_lo = run_f;
            end
            seen_f++; run_f = 1;
         end else run_f++;
         if (tap != prev_t) begin
            if (!tap) tap_hi = run_t; else tap_lo = run_t;
            seen_t++; run_t = 1;
         end else run_t++;
         prev_f = fout; prev_t = tap;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   function automatic int ratio(input logic [1:0] c);
      return (c == 2'b11) ? 1 : (2 << c);
   endfunction

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      end
      $finish;
   end

   initial begin
      cyc(3);
      chk("R6 reset clk_o", int'(fout), 0);
      chk("R6 reset tap_o", int'(tap), 0);
      arst = 1'b0;
      cyc(20);
      begin
         int hi_seen = 0;
         for (int i = 0; i < 20; i++) begin
            if (fout || tap) hi_seen++;
            @(clk); #1;
         end
         chk("R6 idle after reset", hi_seen, 0);
      end

      // R1 R2 R7 R8: steady widths for each code
      en = 1'b1;
      for (int c = 0; c < 4; c++) begin
         code = 2'(c);
         cyc(150);
         chk($sformatf("R1 R2 high width code %0d", c), last_hi, ratio(code));
         chk($sformatf("R2 low width code %0d", c), last_lo, ratio(code));
         chk($sformatf("R7 tap high code %0d", c), tap_hi, 4 * ratio(code));
         chk($sformatf("R7 tap low code %0d", c), tap_lo, 4 * ratio(code));
      end
      code = 2'b11;
      cyc(20);
      chk("R8 bypass high", last_hi, 1);
      chk("R8 bypass tap period", tap_hi + tap_lo, 8);

      // R3: disabled output low and tap frozen
      en = 1'b0;
      cyc(20);
      begin
         int hi_seen = 0, tap_moves = 0;
         logic t0;
         t0 = tap;
         for (int i = 0; i < 40; i++) begin
            if (fout) hi_seen++;
            if (tap != t0) tap_moves++;
            @(clk); #1;
         end
         chk("R3 disabled clk_o low", hi_seen, 0);
         chk("R3 disabled tap frozen", tap_moves, 0);
      end

      // R5: code change inside a divide-by-8 pulse
      code = 2'b10; en = 1'b1;
      cyc(40);
      while (fout) cyc(1);
      while (!fout) cyc(1);
      cyc(1);
      code = 2'b00;
      while (fout) cyc(1);
      chk("R5 pulse kept at /8 width", last_hi, 8);
      cyc(30);
      chk("R5 new code applied", last_hi, 2);

      // R4: every ordered pair of codes, plus enable toggles at each offset
      for (int a = 0; a < 4; a++) begin
         for (int b = 0; b < 4; b++) begin
            code = 2'(a); cyc(17 + a);
            code = 2'(b); cyc(13 + b);
            en = 1'b0; cyc(3 + a);
            en = 1'b1; cyc(5);
         end
      end
      for (int c = 0; c < 4; c++) begin
         code = 2'(c);
         for (int k = 0; k < 16; k++) begin
            cyc(k + 1); en = 1'b0;
            cyc((k % 5) + 1); en = 1'b1;
         end
      end
      cyc(40);
      chk("R4 no runt pulses over transitions", runts, 0);

      // R6: reset mid-run forces both outputs low
      code = 2'b01; en = 1'b1;
      cyc(30);
      arst = 1'b1;
      cyc(1);
      chk("R6 mid-run reset clk_o", int'(fout), 0);
      chk("R6 mid-run reset tap_o", int'(tap), 0);
      arst = 1'b0;
      cyc(60);
      chk("R2 after reset high", last_hi, 4);
      chk("R4 no runt after reset", runts, 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule